// File: doc/BRIEF.md
# Reciprocal Seed Lookup for Logarithm Range Reduction

This block is the first stage of a branch-free logarithm pipeline. It accepts one IEEE double-precision operand and returns an approximate reciprocal in a wider-exponent format. A later multiply-add uses that reciprocal to scale the operand into a narrow interval around one. The approximation is taken from a small constant table inside the block. The table is indexed by the leading bits of the normalized significand, so the reduced argument always lands in a fixed, known interval.

The output word has a sign bit, a 12-bit exponent and a 51-bit stored mantissa. The extra exponent bit lets the reciprocal of every double be represented as a normal value, subnormal operands included. Subnormal operands are normalized by a leading-zero count rather than by a separate path. Zero, infinity and NaN leave as reserved exponent codes, so the downstream multiply-add can replace its ordinary result without a branch. A transfer takes one cycle, marked by a valid strobe, and there is no backpressure.

Top module: `seedLookup`

## Requirements
- R1: The output packs sign in bit 63, a 12-bit exponent biased by 2047 in bits 62:51, and a 51-bit mantissa in bits 50:0 with a hidden leading one.
- R2: For a normal input with biased exponent E and table index i = fraction bits 51:46, the output exponent is 3069 - E + b and the mantissa is the table mantissa of entry i, where b is the entry's extra exponent bit.
- R3: Table entry 0 holds b = 1 and mantissa 0, which encodes exactly 1.0. Every entry i > 0 holds b = 0 and mantissa floor(2^58 / (64 + i)) - 2^51, which encodes 64/(64+i).
- R4: For every non-NaN input, the output sign equals the input sign.
- R5: Any NaN input (exponent all ones, fraction nonzero) gives sign 0, exponent 4095, and a mantissa with only bit 50 set (quiet NaN code).
- R6: A zero input (either sign) gives exponent 4095 with mantissa 0 (infinity code). An infinite input gives exponent 0 with mantissa 0 (zero code).
- R7: For a subnormal input, z is the number of leading zeros in the 52-bit fraction. The index is bits 51:46 of the fraction shifted left by z+1, and the output exponent is 3069 + z + b.
- R8: validOut equals validIn delayed by one clock. resOut changes only in the cycle after validIn is high and otherwise holds its value.
- R9: While reset is asserted (rstN low), validOut is 0 and resOut is 0.
- R10: The output never carries exponent 0 with a nonzero mantissa, so no extended subnormal is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operand on dataIn is valid this cycle |
| dataIn | input | 64 | IEEE double-precision operand |
| validOut | output | 1 | resOut carries a new result |
| resOut | output | 64 | Extended-range reciprocal seed |

## Verification
Operands equal to 1.0 and at each of the 64 index boundaries fix the table contents and the exact-endpoint entry. Exponents at the smallest and largest normal values separate the exponent subtraction from off-by-one errors. Subnormals with the first set bit at the top, in the middle and at the very bottom of the fraction exercise the leading-zero count, the normalizing shift and the second exponent candidate. Signed zeros, infinities, quiet and signalling NaNs, and a long pseudorandom stream then check the reserved codes, sign handling and the hold behaviour between gaps.

// File: rtl/seed_pkg.sv
package seed_pkg;

  localparam int IEEE_BIAS = 1023;
  localparam int EXT_BIAS  = 2047;
  // Biased output exponent of a seed for input exponent E: EXT_BIAS + IEEE_BIAS - 1 - E
  localparam int RED_BASE  = EXT_BIAS + IEEE_BIAS - 1;

  typedef struct packed {
    logic valid;
    logic isNaN;
    logic isInf;
    logic isZero;
    logic isSub;
  } seedStrobe_t;

  // Entry {extraExpBit, mantissa[50:0]} for seed value 2^idxW / (2^idxW + idx)
  function automatic logic [51:0] seedEntry(input int idx, input int idxW);
    logic [63:0] num;
    logic [63:0] quo;
    logic [63:0] frac;
    if (idx == 0) begin
      return {1'b1, 51'd0};
    end
    num  = 64'd1 << (52 + idxW);
    quo  = num / 64'((1 << idxW) + idx);
    frac = quo - (64'd1 << 51);
    return {1'b0, frac[50:0]};
  endfunction

endpackage

// File: rtl/seedCtrl.sv
module seedCtrl
  import seed_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [10:0] expIn,
  input  logic [51:0] fracIn,
  output seedStrobe_t strobe,
  output logic        validOut
);

  logic expMax;
  logic expMin;
  logic fracZero;

  always_comb begin
    expMax   = &expIn;
    expMin   = ~|expIn;
    fracZero = ~|fracIn;
    strobe.valid  = validIn;
    strobe.isNaN  = expMax & ~fracZero;
    strobe.isInf  = expMax & fracZero;
    strobe.isZero = expMin & fracZero;
    strobe.isSub  = expMin & ~fracZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  // R8: one-cycle valid latency
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

endmodule

// File: rtl/seedPath.sv
module seedPath
  import seed_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] dataIn,
  input  seedStrobe_t strobe,
  output logic [63:0] resOut
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int FRAC_W  = 52;

  logic [51:0] romTable [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign romTable[g] = seedEntry(g, IDX_W);
  end

  logic              signIn;
  logic [10:0]       expIn;
  logic [FRAC_W-1:0] fracIn;
  logic [5:0]        lzCnt;
  logic              lzFound;
  logic [FRAC_W-1:0] fracNorm;
  logic [IDX_W-1:0]  idx;
  logic [51:0]       entry;
  logic [11:0]       expNorm;
  logic [11:0]       expSub;
  logic [11:0]       expFinal;
  logic [63:0]       resNext;

  assign signIn = dataIn[63];
  assign expIn  = dataIn[62:52];
  assign fracIn = dataIn[51:0];

  // Leading-zero count over the fraction
  always_comb begin
    lzCnt   = '0;
    lzFound = 1'b0;
    for (int k = FRAC_W - 1; k >= 0; k--) begin
      if (!lzFound) begin
        if (fracIn[k]) lzFound = 1'b1;
        else           lzCnt   = lzCnt + 6'd1;
      end
    end
  end

  always_comb begin
    fracNorm = strobe.isSub ? (fracIn << (lzCnt + 6'd1)) : fracIn;
    idx      = fracNorm[FRAC_W-1 -: IDX_W];
    entry    = romTable[idx];
    expNorm  = 12'(RED_BASE) - {1'b0, expIn};
    expSub   = 12'(RED_BASE) + {6'd0, lzCnt};
    expFinal = (strobe.isSub ? expSub : expNorm) + {11'd0, entry[51]};
    if (strobe.isNaN)       resNext = {1'b0, 12'hFFF, 1'b1, 50'd0};
    else if (strobe.isZero) resNext = {signIn, 12'hFFF, 51'd0};
    else if (strobe.isInf)  resNext = {signIn, 12'h000, 51'd0};
    else                    resNext = {signIn, expFinal, entry[50:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resOut <= '0;
    else if (strobe.valid) resOut <= resNext;
  end

  // R5: NaN leaves as the quiet NaN code
  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid && strobe.isNaN |=> (resOut[62:51] == 12'hFFF) && resOut[50]);
  // R4: sign carried for non-NaN input
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid && !strobe.isNaN |=> resOut[63] == $past(signIn));
  // R7: subnormal seeds sit above the normal exponent range
  a_r7_sub_exp_high: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid && strobe.isSub |=> resOut[62:51] >= 12'(RED_BASE));
  // R8: hold while idle
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.valid |=> $stable(resOut));
  // R10: no extended subnormal
  a_r10_no_subnormal: assert property (@(posedge clk) disable iff (!rstN)
    resOut[62:51] == 12'h000 |-> resOut[50:0] == 51'd0);

endmodule

// File: rtl/seedLookup.sv
module seedLookup
  import seed_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [63:0] dataIn,
  output logic        validOut,
  output logic [63:0] resOut
);

  seedStrobe_t strobe;

  seedCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .expIn    (dataIn[62:52]),
    .fracIn   (dataIn[51:0]),
    .strobe   (strobe),
    .validOut (validOut)
  );

  seedPath #(.IDX_W(IDX_W)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .strobe (strobe),
    .resOut (resOut)
  );

endmodule

// File: tb/sim_seedLookup.sv
`timescale 1ns/1ps
module sim_seedLookup;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [63:0] dataIn = '0;
  logic        validOut;
  logic [63:0] resOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] want;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [63:0] lastWant = '0;
  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  seedLookup u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .dataIn(dataIn),
    .validOut(validOut), .resOut(resOut)
  );

  function automatic logic [63:0] model(input logic [63:0] x);
    logic        s;
    logic [10:0] e;
    logic [51:0] f;
    logic [51:0] g;
    int          z;
    int          base;
    int          i;
    logic        b;
    logic [63:0] m;
    logic [11:0] eo;
    s = x[63]; e = x[62:52]; f = x[51:0];
    if (e == 11'h7FF) begin
      if (f != 0) return {1'b0, 12'hFFF, 1'b1, 50'd0};
      return {s, 12'h000, 51'd0};
    end
    if (e == 0 && f == 0) return {s, 12'hFFF, 51'd0};
    if (e == 0) begin
      z = 0;
      while (f[51 - z] == 1'b0) z++;
      g = f << (z + 1);
      i = int'(g[51:46]);
      base = 3069 + z;
    end else begin
      i = int'(f[51:46]);
      base = 3069 - int'(e);
    end
    if (i == 0) begin
      b = 1'b1; m = 64'd0;
    end else begin
      b = 1'b0; m = ((64'd1 << 58) / 64'(64 + i)) - (64'd1 << 51);
    end
    eo = 12'(base + int'(b));
    return {s, eo, m[50:0]};
  endfunction

  task automatic check(input logic [63:0] got, input logic [63:0] want, input string tag);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got=%h want=%h", tag, got, want);
    end
  endtask

  task automatic send(input logic [63:0] x, input string tag);
    item_t it;
    @(negedge clk);
    dataIn  = x;
    validIn = 1'b1;
    it.want = model(x);
    it.tag  = tag;
    lastWant = it.want;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      validIn = 1'b0;
      dataIn  = 64'hFFFF_0000_DEAD_BEEF;
    end
  endtask

  // Monitor: compare outputs against the scoreboard
  always @(negedge clk) begin
    if (rstN && validOut) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected validOut got=1 want=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        check(resOut, it.want, it.tag);
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout want=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({63'd0, validOut}, 64'd0, "R9 validOut in reset");
    check(resOut, 64'd0, "R9 resOut in reset");
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2: 1.0 gives exactly 1.0 in the wide format
    send(64'h3FF0_0000_0000_0000, "R1 R2 one");
    send(64'h3FF8_0000_0000_0000, "R2 one-and-half");
    send(64'hC00E_0000_0000_0000, "R2 R4 negative");
    send(64'h0010_0000_0000_0000, "R2 min normal");
    send(64'h7FEF_FFFF_FFFF_FFFF, "R2 max normal");
    // R3: every table index
    for (int i = 0; i < 64; i++) begin
      send({1'b0, 11'd1023, 6'(i), 46'h1234_5678_9AB}, "R3 table sweep");
    end
    // R7: subnormal leading-zero positions
    send(64'h0008_0000_0000_0000, "R7 sub z0");
    send(64'h0000_0000_0000_0001, "R7 sub z51");
    send(64'h8000_0001_2345_6789, "R7 R4 sub mid");
    send(64'h000F_FFFF_FFFF_FFFF, "R7 sub max");
    // R5 R6: specials
    send(64'h7FF8_0000_0000_0000, "R5 qnan");
    send(64'hFFF0_0000_0000_0001, "R5 snan neg");
    send(64'h0000_0000_0000_0000, "R6 zero");
    send(64'h8000_0000_0000_0000, "R6 R4 negzero");
    send(64'h7FF0_0000_0000_0000, "R6 inf");
    send(64'hFFF0_0000_0000_0000, "R6 R4 neginf");
    send(64'h4045_2000_0000_0000, "R8 before gap");
    idle(3);
    check({63'd0, validOut}, 64'd0, "R8 validOut idle");
    check(resOut, lastWant, "R8 hold while idle");
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      send(lfsr, "R2 R10 random");
      if (n % 37 == 0) begin
        idle(2);
        check(resOut, lastWant, "R8 hold random gap");
      end
    end
    idle(4);
    check(64'(sb.size()), 64'd0, "R8 scoreboard drained");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule